// File: doc/BRIEF.md
# Two-Wire Gray Strobe Sequencer

This block is the timing generator of a narrow source-clocked transmitter. It drives two strobe wires through a short Gray-code walk in which exactly one wire toggles per clock. The receiving side latches data on every strobe edge. A transfer ends when both wires are back at zero. The walk has four shapes, picked by two selects. Direction picks which wire moves first: the forward order is used for payload and the reverse order for control traffic. Length picks either a four-edge walk or a two-edge walk. In the two-edge walk only one wire pulses.

A single-cycle launch pulse starts a walk, but only while the block reports idle. The block also exports a step index that names the nibble the bus should carry next. An outside 4-to-1 multiplexer uses it to serve a 16-bit word, least significant nibble first, so the data always settles before the strobe edge that captures it. A synchronous active-low clear returns everything to rest.

Top module: `gray_strobe_seq`

## Requirements
- R1: With `clr_n` low at a rising edge, after that edge `{strobe_a,strobe_b}` is 2'b00, `idle` is 1 and `step_idx` is 0, whatever `start` does. Clear takes priority over launch.
- R2: With `dir_rev`=0 and `short_len`=0 at an accepted launch, `{strobe_a,strobe_b}` takes the values 2, 3, 1, 0 after the 1st, 2nd, 3rd and 4th edge.
- R3: With `dir_rev`=1 and `short_len`=0 at an accepted launch, `{strobe_a,strobe_b}` takes the values 1, 3, 2, 0 after the 1st to 4th edge.
- R4: With `short_len`=1 at an accepted launch, `{strobe_a,strobe_b}` takes the values 2 then 0 when `dir_rev`=0, and 1 then 0 when `dir_rev`=1.
- R5: `start` is accepted only when `idle` is 1 at that edge. A `start` seen while busy has no effect on the strobes, the step index or the walk's length.
- R6: `idle` falls on the edge that accepts a launch. It rises on the edge that returns the strobes to 2'b00, and it is never high while a strobe is high.
- R7: On any edge, at most one of the two strobe wires changes value.
- R8: `dir_rev` and `short_len` are sampled only on an accepted launch. Changing them mid-walk does not alter the walk in progress.
- R9: `step_idx` is 0 while idle. It increases by one after each strobe edge and wraps to 0 on the edge that ends the walk. A 4-edge walk therefore shows 1, 2, 3, 0 and a 2-edge walk shows 1, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| start | input | 1 | One-cycle launch request |
| dir_rev | input | 1 | 0 = forward walk (wire A leads), 1 = reverse walk (wire B leads) |
| short_len | input | 1 | 0 = four-edge walk, 1 = two-edge walk |
| strobe_a | output | 1 | Strobe wire A, registered |
| strobe_b | output | 1 | Strobe wire B, registered |
| idle | output | 1 | High when at rest and able to accept a launch |
| step_idx | output | 2 | Index of the nibble to present before the next strobe edge |

## Verification
The clocked assertions assume that `clr_n` is held low for at least two edges after power-up, so that every `$past` value they use comes from a cleared register. They also assume that the selects and `start` change only away from the rising edge. The stimulus drives all inputs at a fixed delay after the edge, holds clear low for several cycles at the start, and asserts `start` only as whole-cycle pulses. It sweeps all four walk shapes both undisturbed and with `start` and inverted selects held high through the whole walk. It also covers a clear in the middle of a walk and a clear that coincides with a launch.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
  localparam int unsigned STEP_W = 2;
  typedef logic [STEP_W-1:0] step_t;
  typedef logic [1:0]        code_t;

  // Last step index for a walk length: 4-edge walk ends at 3, 2-edge at 1.
  function automatic step_t last_step(input logic short_len);
    return short_len ? step_t'(1) : step_t'(3);
  endfunction

  // Binary to reflected Gray.
  function automatic code_t to_gray(input step_t s);
    return code_t'(s ^ (s >> 1));
  endfunction
endpackage

// File: rtl/gseq_counter.sv
module gseq_counter
  import gseq_pkg::*;
(
  input  logic  clk,
  input  logic  clr_n,
  input  logic  start,
  input  logic  dir_in,
  input  logic  short_in,
  output step_t cnt_q,
  output step_t cnt_d,
  output logic  busy_q,
  output logic  dir_q,
  output logic  dir_d,
  output logic  launch,
  output logic  wrap
);
  logic  short_q, short_d, busy_d;

  assign launch = start & ~busy_q;
  assign wrap   = busy_q & (cnt_q == last_step(short_q));

  always_comb begin
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    dir_d   = dir_q;
    short_d = short_q;
    if (!clr_n) begin
      cnt_d   = '0;
      busy_d  = 1'b0;
      dir_d   = 1'b0;
      short_d = 1'b0;
    end else if (launch) begin
      cnt_d   = step_t'(1);
      busy_d  = 1'b1;
      dir_d   = dir_in;
      short_d = short_in;
    end else if (wrap) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + step_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    cnt_q   <= cnt_d;
    busy_q  <= busy_d;
    dir_q   <= dir_d;
    short_q <= short_d;
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!clr_n)
    busy_q |=> ($stable(dir_q) && $stable(short_q))) else $error("cfg changed"); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!clr_n)
    (busy_q && start) |=> (cnt_q != step_t'(1))) else $error("start while busy"); // R5
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!clr_n)
    busy_q |=> ((cnt_q == $past(cnt_q) + step_t'(1)) || (cnt_q == '0 && !busy_q)))
    else $error("step skip"); // R9
endmodule

// File: rtl/gseq_strobe_map.sv
module gseq_strobe_map
  import gseq_pkg::*;
(
  input  step_t step,
  input  logic  dir_rev,
  output code_t code
);
  code_t g;
  assign g = to_gray(step);
  // Forward walk leads with wire A: swap the two Gray bits through a mux pair.
  assign code[1] = dir_rev ? g[1] : g[0];
  assign code[0] = dir_rev ? g[0] : g[1];
endmodule

// File: rtl/gray_strobe_seq.sv
module gray_strobe_seq
  import gseq_pkg::*;
(
  input  logic       clk,
  input  logic       clr_n,
  input  logic       start,
  input  logic       dir_rev,
  input  logic       short_len,
  output logic       strobe_a,
  output logic       strobe_b,
  output logic       idle,
  output logic [1:0] step_idx
);
  step_t cnt_q, cnt_d;
  logic  busy_q, dir_q, dir_d, launch, wrap;
  code_t code_d;

  gseq_counter u_cnt (
    .clk(clk), .clr_n(clr_n), .start(start), .dir_in(dir_rev),
    .short_in(short_len), .cnt_q(cnt_q), .cnt_d(cnt_d), .busy_q(busy_q),
    .dir_q(dir_q), .dir_d(dir_d), .launch(launch), .wrap(wrap)
  );

  gseq_strobe_map u_map (.step(cnt_d), .dir_rev(dir_d), .code(code_d));

  always_ff @(posedge clk) begin
    strobe_a <= code_d[1];
    strobe_b <= code_d[0];
  end

  assign idle     = ~busy_q;
  assign step_idx = cnt_q;

  AST_CLEAR_REST: assert property (@(posedge clk)
    !clr_n |=> (idle && step_idx == 2'd0 && !strobe_a && !strobe_b))
    else $error("clear"); // R1
  AST_ONE_WIRE: assert property (@(posedge clk) disable iff (!clr_n)
    1'b1 |=> ($countones({strobe_a, strobe_b} ^ $past({strobe_a, strobe_b})) <= 1))
    else $error("two wires moved"); // R7
  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    idle |-> (!strobe_a && !strobe_b)) else $error("idle with strobe"); // R6
  AST_LAUNCH_DROPS_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    launch |=> (!idle && (strobe_a ^ strobe_b))) else $error("launch"); // R6
  AST_WRAP_ENDS: assert property (@(posedge clk) disable iff (!clr_n)
    wrap |=> (idle && !strobe_a && !strobe_b)) else $error("wrap"); // R6
endmodule

// File: tb/gray_strobe_seq_test.sv
module gray_strobe_seq_test;
  logic clk = 1'b0, clr_n = 1'b0, start = 1'b0, dir_rev = 1'b0, short_len = 1'b0;
  logic strobe_a, strobe_b, idle;
  logic [1:0] step_idx;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gray_strobe_seq uut (
    .clk(clk), .clr_n(clr_n), .start(start), .dir_rev(dir_rev),
    .short_len(short_len), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .idle(idle), .step_idx(step_idx)
  );

  // Expected wire code for step k: Gray of k, wires swapped for forward walk.
  function automatic logic [1:0] exp_code(input int k, input logic rev);
    int g = (k ^ (k >> 1)) & 3;
    return rev ? 2'(g) : {g[0], g[1]};
  endfunction

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act = {strobe_a, strobe_b, idle, step_idx};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {a,b,idle,step} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  // Walk one sequence; if disturb, hold start high with inverted selects.
  task automatic run_walk(input logic rev, input logic shrt, input bit disturb);
    int steps = shrt ? 2 : 4;
    logic [1:0] prev = 2'b00;
    string req = shrt ? "R4" : (rev ? "R3" : "R2");
    start = 1'b1; dir_rev = rev; short_len = shrt;
    edge1();
    start = 1'b0;
    for (int k = 1; k <= steps; k++) begin
      if (k < steps) chk(disturb ? "R8/R5" : req, {exp_code(k, rev), 1'b0, 2'(k)});
      else           chk("R6 R9 end", 5'b00100);
      tests++;
      if ($countones({strobe_a, strobe_b} ^ prev) > 1) begin
        fails++;
        $display("FAIL R7: wires %b after %b, expected one change", {strobe_a, strobe_b}, prev);
      end
      prev = {strobe_a, strobe_b};
      if (disturb && k < steps) begin
        start = 1'b1; dir_rev = ~rev; short_len = ~shrt;
      end else begin
        start = 1'b0;
      end
      if (k < steps) edge1();
    end
    start = 1'b0;
    edge1();
    chk("R5 stays idle", 5'b00100);
  endtask

  initial begin
    repeat (4) edge1();
    chk("R1 reset", 5'b00100);
    clr_n = 1'b1;
    edge1();
    chk("R9 idle step 0", 5'b00100);
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int x = 0; x < 2; x++)
          run_walk(1'(s), 1'(d), bit'(x));
    // Back-to-back launches right after the end of a walk.
    run_walk(1'b0, 1'b0, 1'b0);
    run_walk(1'b1, 1'b1, 1'b0);
    // Clear mid-walk.
    start = 1'b1; dir_rev = 1'b0; short_len = 1'b0;
    edge1(); start = 1'b0;
    edge1();
    chk("R2 mid", {exp_code(2, 1'b0), 1'b0, 2'd2});
    clr_n = 1'b0;
    edge1();
    chk("R1 clear mid-walk", 5'b00100);
    // Clear together with launch.
    start = 1'b1;
    edge1();
    chk("R1 clear beats start", 5'b00100);
    clr_n = 1'b1; start = 1'b0;
    edge1();
    chk("R1 released idle", 5'b00100);
    run_walk(1'b1, 1'b0, 1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule